// File: doc/BRIEF.md
# Chained Vector Arithmetic Slice

This block executes register-to-register vector instructions on integer elements. It holds a file of eight vector registers. Each register has 64 elements of 64 bits. Two pipelined units work on that file: a six-stage adder and a seven-stage multiplier. One issued instruction names two source registers, an optional third source, a destination register, an operation code and an element count. The slice then sends one element pair per clock into the selected unit and writes one result per clock back into the destination.

In chained mode, each sum that leaves the adder goes straight into the multiplier, paired with the matching element of the third source. The multiplier therefore starts on element 0 while the adder is still working on later elements. The two units together behave as a single 13-stage pipe. A 64-element sum-then-product finishes in 76 clocks. Run as two separate instructions, the same work needs 69 + 70 clocks.

A load port writes any single element, and a combinational debug port reads any element. The surrounding logic or a testbench uses these to place operands and to inspect results. Only one instruction is in flight at a time. A busy flag and a one-cycle done pulse bracket its execution.

Top module: `vec_chain_slice`

## Requirements
- R1: The file holds 8 registers of 64 elements of 64 bits. A load (`ld_we`=1) writes `ld_data` to element `ld_idx` of register `ld_reg` at the clock edge. `dbg_data` shows element `dbg_idx` of register `dbg_reg` combinationally.
- R2: Operation code 0 (add) writes d[i] = a[i] + b[i] modulo 2^64 for every element i below the length.
- R3: Operation code 1 (multiply) writes d[i] = the low 64 bits of a[i] * b[i].
- R4: Operation codes 2 and 3 (chained) write d[i] = low 64 bits of (a[i] + b[i]) * c[i]. Here a, b and c are registers `iss_va`, `iss_vb` and `iss_vc`.
- R5: An instruction is accepted at edge E. Element i is then written at edge E+L+i, where L is 6 for add, 7 for multiply and 13 for chained.
- R6: For a length n ≥ 1, `done` is high for exactly the one cycle after edge E+L+n−1. `busy` is high from edge E until that same edge. A 64-element chained instruction therefore completes at E+76.
- R7: An issue presented while `busy` is high is ignored. Its destination stays unchanged, and no extra busy period or done pulse follows.
- R8: Elements at or above the length in the destination keep their previous values.
- R9: A length of 0 pulses `done` in the cycle after the accepting edge. `busy` stays low and nothing is written.
- R10: A length above 64 is treated as 64.
- R11: While reset is asserted, `busy` and `done` are low, including when reset arrives during a running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | 0 add, 1 multiply, 2 or 3 chained add-then-multiply |
| iss_va | input | 3 | First source register |
| iss_vb | input | 3 | Second source register |
| iss_vc | input | 3 | Multiplier operand register for chained mode |
| iss_vd | input | 3 | Destination register |
| iss_len | input | 7 | Element count, 0 to 64 (larger values capped) |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle pulse after the last write |
| ld_we | input | 1 | Element load strobe |
| ld_reg | input | 3 | Load register select |
| ld_idx | input | 6 | Load element index |
| ld_data | input | 64 | Load value |
| dbg_reg | input | 3 | Debug read register select |
| dbg_idx | input | 6 | Debug read element index |
| dbg_data | output | 64 | Debug read value |

## Verification
Element 0 of a result is due L clocks after the accepting edge. The done pulse is due L+n−1 clocks after that edge, and 0 clocks after it for an empty instruction. The bench counts falling edges from the accepting edge. At each one it reads element 0 of the destination through the debug port and samples `done`, so both arrival times are measured to the exact cycle and compared with those formulas. Whole-register contents are compared against a bench-side model only after done, and the rejected-issue case is judged by the destination contents plus a quiet window in which neither busy nor done may rise.

// File: rtl/vec_chain_pkg.sv
package vec_chain_pkg;

  parameter int NUM_VREG  = 8;
  parameter int VEC_LEN   = 64;
  parameter int ELEM_W    = 64;
  parameter int ADD_DEPTH = 6;
  parameter int MUL_DEPTH = 7;

  // Which unit(s) an instruction occupies
  typedef enum logic [1:0] {
    K_ADD   = 2'd0,
    K_MUL   = 2'd1,
    K_CHAIN = 2'd2
  } kind_t;

  function automatic kind_t op_kind(input logic [1:0] op);
    case (op)
      2'd0:    return K_ADD;
      2'd1:    return K_MUL;
      default: return K_CHAIN;
    endcase
  endfunction

endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int EW   = 64,
  parameter int NRD  = 4,
  parameter int RW   = 3,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wr_reg,
  input  logic [IW-1:0] wr_idx,
  input  logic [EW-1:0] wr_data,
  input  logic [RW-1:0] rd_reg  [NRD],
  input  logic [IW-1:0] rd_idx  [NRD],
  output logic [EW-1:0] rd_data [NRD]
);

  logic [EW-1:0] mem [NREG][VLEN];

  // single write port, clock-enabled
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wr_reg][wr_idx] <= wr_data;
    end
  end

  // combinational read ports
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_reg[p]][rd_idx[p]];
  end

endmodule

// File: rtl/vec_fu_pipe.sv
module vec_fu_pipe #(
  parameter int EW     = 64,
  parameter int IW     = 6,
  parameter int STAGES = 6,
  parameter bit MUL    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [IW-1:0] in_idx,
  input  logic [EW-1:0] in_x,
  input  logic [EW-1:0] in_y,
  output logic          out_vld,
  output logic [IW-1:0] out_idx,
  output logic [EW-1:0] out_data
);

  logic [EW-1:0] res;

  if (MUL) begin : g_mul
    assign res = in_x * in_y;
  end else begin : g_add
    assign res = in_x + in_y;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic          v_d, v_q;
    logic [IW-1:0] i_d, i_q;
    logic [EW-1:0] x_d, x_q;

    if (s == 0) begin : g_in
      assign v_d = in_vld;
      assign i_d = in_idx;
      assign x_d = res;
    end else begin : g_link
      assign v_d = g_st[s-1].v_q;
      assign i_d = g_st[s-1].i_q;
      assign x_d = g_st[s-1].x_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    // payload only moves with a valid token
    always_ff @(posedge clk) begin
      if (v_d) begin
        i_q <= i_d;
        x_q <= x_d;
      end
    end
  end

  assign out_vld  = g_st[STAGES-1].v_q;
  assign out_idx  = g_st[STAGES-1].i_q;
  assign out_data = g_st[STAGES-1].x_q;

endmodule

// File: rtl/vec_seq.sv
module vec_seq
  import vec_chain_pkg::*;
#(
  parameter int VLEN = 64,
  parameter int RW   = 3,
  parameter int IW   = 6,
  parameter int LW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic [RW-1:0] iss_va,
  input  logic [RW-1:0] iss_vb,
  input  logic [RW-1:0] iss_vc,
  input  logic [RW-1:0] iss_vd,
  input  logic [LW-1:0] iss_len,
  input  logic          wb_vld,
  input  logic [IW-1:0] wb_idx,
  output logic          busy,
  output logic          done,
  output logic          feed_vld,
  output logic [IW-1:0] feed_idx,
  output kind_t         ent_kind,
  output logic [RW-1:0] ent_va,
  output logic [RW-1:0] ent_vb,
  output kind_t         run_kind,
  output logic [RW-1:0] run_vc,
  output logic [RW-1:0] run_vd,
  output logic [LW-1:0] run_len
);

  localparam logic [LW-1:0] LEN_MAX = LW'(VLEN);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q;
  kind_t         kind_q;
  logic [RW-1:0] va_q, vb_q, vc_q, vd_q;

  logic          accept;
  logic [LW-1:0] len_cap;
  logic          wb_last;

  // next-state logic
  always_comb begin
    accept  = iss_valid && !busy_q;
    len_cap = (iss_len > LEN_MAX) ? LEN_MAX : iss_len;
    wb_last = wb_vld && (wb_idx == IW'(len_q - 1'b1));

    if (accept) begin
      feed_vld = (len_cap != '0);
      feed_idx = '0;
      ent_kind = op_kind(iss_op);
      ent_va   = iss_va;
      ent_vb   = iss_vb;
    end else begin
      feed_vld = busy_q && (cnt_q < len_q);
      feed_idx = cnt_q[IW-1:0];
      ent_kind = kind_q;
      ent_va   = va_q;
      ent_vb   = vb_q;
    end

    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = (len_cap != '0);
      done_d = (len_cap == '0);
      cnt_d  = (len_cap != '0) ? LW'(1) : '0;
    end else if (busy_q) begin
      if (feed_vld) cnt_d = cnt_q + 1'b1;
      if (wb_last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  // instruction latch, enabled by acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      kind_q <= op_kind(iss_op);
      va_q   <= iss_va;
      vb_q   <= iss_vb;
      vc_q   <= iss_vc;
      vd_q   <= iss_vd;
      len_q  <= len_cap;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign run_kind = kind_q;
  assign run_vc   = vc_q;
  assign run_vd   = vd_q;
  assign run_len  = len_q;

endmodule

// File: rtl/vec_chain_slice.sv
module vec_chain_slice
  import vec_chain_pkg::*;
#(
  parameter int NREG   = NUM_VREG,
  parameter int VLEN   = VEC_LEN,
  parameter int EW     = ELEM_W,
  parameter int ADD_ST = ADD_DEPTH,
  parameter int MUL_ST = MUL_DEPTH,
  localparam int RW    = $clog2(NREG),
  localparam int IW    = $clog2(VLEN),
  localparam int LW    = $clog2(VLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic [RW-1:0] iss_va,
  input  logic [RW-1:0] iss_vb,
  input  logic [RW-1:0] iss_vc,
  input  logic [RW-1:0] iss_vd,
  input  logic [LW-1:0] iss_len,
  output logic          busy,
  output logic          done,
  input  logic          ld_we,
  input  logic [RW-1:0] ld_reg,
  input  logic [IW-1:0] ld_idx,
  input  logic [EW-1:0] ld_data,
  input  logic [RW-1:0] dbg_reg,
  input  logic [IW-1:0] dbg_idx,
  output logic [EW-1:0] dbg_data
);

  localparam int NRD = 4;  // entry a, entry b, chain c, debug

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic          feed_vld;
  logic [IW-1:0] feed_idx;
  kind_t         ent_kind, run_kind;
  logic [RW-1:0] ent_va, ent_vb, run_vc, run_vd;
  logic [LW-1:0] run_len;

  logic          add_in_vld, add_out_vld;
  logic [IW-1:0] add_out_idx;
  logic [EW-1:0] add_out;
  logic          mul_chain, mul_in_vld, mul_out_vld;
  logic [IW-1:0] mul_in_idx, mul_out_idx;
  logic [EW-1:0] mul_x, mul_y, mul_out;

  logic          wb_vld;
  logic [IW-1:0] wb_idx;
  logic [EW-1:0] wb_data;

  logic          rf_we;
  logic [RW-1:0] rf_wreg;
  logic [IW-1:0] rf_widx;
  logic [EW-1:0] rf_wdat;
  logic [RW-1:0] rf_reg [NRD];
  logic [IW-1:0] rf_idx [NRD];
  logic [EW-1:0] rf_dat [NRD];

  vec_seq #(.VLEN(VLEN), .RW(RW), .IW(IW), .LW(LW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .iss_valid(iss_valid),
    .iss_op   (iss_op),
    .iss_va   (iss_va),
    .iss_vb   (iss_vb),
    .iss_vc   (iss_vc),
    .iss_vd   (iss_vd),
    .iss_len  (iss_len),
    .wb_vld   (wb_vld),
    .wb_idx   (wb_idx),
    .busy     (busy),
    .done     (done),
    .feed_vld (feed_vld),
    .feed_idx (feed_idx),
    .ent_kind (ent_kind),
    .ent_va   (ent_va),
    .ent_vb   (ent_vb),
    .run_kind (run_kind),
    .run_vc   (run_vc),
    .run_vd   (run_vd),
    .run_len  (run_len)
  );

  // read port wiring
  always_comb begin
    rf_reg[0] = ent_va;  rf_idx[0] = feed_idx;
    rf_reg[1] = ent_vb;  rf_idx[1] = feed_idx;
    rf_reg[2] = run_vc;  rf_idx[2] = add_out_idx;
    rf_reg[3] = dbg_reg; rf_idx[3] = dbg_idx;
  end
  assign dbg_data = rf_dat[3];

  // operand steering
  always_comb begin
    add_in_vld = feed_vld && (ent_kind != K_MUL);
    mul_chain  = (run_kind == K_CHAIN) && add_out_vld;
    mul_in_vld = mul_chain || (feed_vld && (ent_kind == K_MUL));
    mul_in_idx = mul_chain ? add_out_idx : feed_idx;
    mul_x      = mul_chain ? add_out     : rf_dat[0];
    mul_y      = mul_chain ? rf_dat[2]   : rf_dat[1];
  end

  vec_fu_pipe #(.EW(EW), .IW(IW), .STAGES(ADD_ST), .MUL(1'b0)) u_add (
    .clk     (clk),
    .rst_n   (rst_i),
    .in_vld  (add_in_vld),
    .in_idx  (feed_idx),
    .in_x    (rf_dat[0]),
    .in_y    (rf_dat[1]),
    .out_vld (add_out_vld),
    .out_idx (add_out_idx),
    .out_data(add_out)
  );

  vec_fu_pipe #(.EW(EW), .IW(IW), .STAGES(MUL_ST), .MUL(1'b1)) u_mul (
    .clk     (clk),
    .rst_n   (rst_i),
    .in_vld  (mul_in_vld),
    .in_idx  (mul_in_idx),
    .in_x    (mul_x),
    .in_y    (mul_y),
    .out_vld (mul_out_vld),
    .out_idx (mul_out_idx),
    .out_data(mul_out)
  );

  // writeback, with priority over the load port
  always_comb begin
    wb_vld  = mul_out_vld || (add_out_vld && (run_kind == K_ADD));
    wb_idx  = mul_out_vld ? mul_out_idx : add_out_idx;
    wb_data = mul_out_vld ? mul_out     : add_out;
    rf_we   = wb_vld || ld_we;
    rf_wreg = wb_vld ? run_vd  : ld_reg;
    rf_widx = wb_vld ? wb_idx  : ld_idx;
    rf_wdat = wb_vld ? wb_data : ld_data;
  end

  vec_regfile #(.NREG(NREG), .VLEN(VLEN), .EW(EW), .NRD(NRD), .RW(RW), .IW(IW)) u_rf (
    .clk    (clk),
    .we     (rf_we),
    .wr_reg (rf_wreg),
    .wr_idx (rf_widx),
    .wr_data(rf_wdat),
    .rd_reg (rf_reg),
    .rd_idx (rf_idx),
    .rd_data(rf_dat)
  );

endmodule

// File: rtl/vec_chain_chk.sv
module vec_chain_chk #(
  parameter int VLEN = 64,
  parameter int IW   = 6,
  parameter int LW   = 7
) (
  input logic          clk,
  input logic          rst_i,
  input logic          busy,
  input logic          done,
  input logic          iss_valid,
  input logic [LW-1:0] iss_len,
  input logic          wb_vld,
  input logic [IW-1:0] wb_idx,
  input logic [LW-1:0] run_len
);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> !busy);  // R6

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(busy) |-> done);  // R6

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && !wb_vld) |=> busy);  // R7

  AST_WB_IN_RUN: assert property (@(posedge clk) disable iff (!rst_i)
    wb_vld |-> busy);  // R5

  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    (wb_vld && $past(wb_vld)) |-> (wb_idx == IW'($past(wb_idx) + 1'b1)));  // R5

  AST_WB_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_i)
    wb_vld |-> ({1'b0, wb_idx} < run_len));  // R8

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_i)
    (iss_valid && !busy && (iss_len == '0)) |=> (done && !busy));  // R9

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_i)
    busy |-> ((run_len <= LW'(VLEN)) && (run_len != '0)));  // R10

endmodule

bind vec_chain_slice vec_chain_chk #(.VLEN(VLEN), .IW(IW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_i    (rst_i),
  .busy     (busy),
  .done     (done),
  .iss_valid(iss_valid),
  .iss_len  (iss_len),
  .wb_vld   (wb_vld),
  .wb_idx   (wb_idx),
  .run_len  (run_len)
);

// File: tb/tb_vec_chain_slice.sv
module tb_vec_chain_slice;

  logic        clk;
  logic        rst_n;
  logic        iss_valid;
  logic [1:0]  iss_op;
  logic [2:0]  iss_va, iss_vb, iss_vc, iss_vd;
  logic [6:0]  iss_len;
  logic        busy, done;
  logic        ld_we;
  logic [2:0]  ld_reg;
  logic [5:0]  ld_idx;
  logic [63:0] ld_data;
  logic [2:0]  dbg_reg;
  logic [5:0]  dbg_idx;
  logic [63:0] dbg_data;

  int checks = 0;
  int errors = 0;

  logic [63:0] mdl [8][64];

  // {op[1:0], va, vb, vc, vd, len[6:0]}
  localparam logic [20:0] TBL [8] = '{
    {2'd0, 3'd0, 3'd1, 3'd0, 3'd2, 7'd64},   // add full
    {2'd1, 3'd3, 3'd4, 3'd0, 3'd5, 7'd64},   // multiply full
    {2'd2, 3'd0, 3'd1, 3'd3, 3'd6, 7'd64},   // chained full, 76 clocks
    {2'd0, 3'd2, 3'd6, 3'd0, 3'd7, 7'd10},   // partial add
    {2'd1, 3'd1, 3'd7, 3'd0, 3'd4, 7'd1},    // single element multiply
    {2'd3, 3'd5, 3'd2, 3'd0, 3'd1, 7'd33},   // chained via code 3
    {2'd0, 3'd4, 3'd4, 3'd0, 3'd3, 7'd100},  // length capped
    {2'd0, 3'd2, 3'd0, 3'd0, 3'd2, 7'd5}     // in place
  };

  vec_chain_slice dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_va(iss_va), .iss_vb(iss_vb),
    .iss_vc(iss_vc), .iss_vd(iss_vd), .iss_len(iss_len),
    .busy(busy), .done(done),
    .ld_we(ld_we), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
    .dbg_reg(dbg_reg), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;  // 10 ns period

  function automatic logic [63:0] pat(input int r, input int i);
    return (64'h9E3779B97F4A7C15 * 64'(r * 64 + i + 1)) ^ (64'(i) << 40) ^ 64'(r);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_issue(input logic [20:0] ins);
    iss_op    = ins[20:19];
    iss_va    = ins[18:16];
    iss_vb    = ins[15:13];
    iss_vc    = ins[12:10];
    iss_vd    = ins[9:7];
    iss_len   = ins[6:0];
    iss_valid = 1'b1;
  endtask

  // issue one instruction, time its first write and its done pulse, then compare the register
  task automatic run_instr(input logic [20:0] ins, input int intr_at, input logic [20:0] intr_ins);
    logic [1:0]  op;
    int          va, vb, vc, vd, n, lat, mfirst, mdone, quiet_bad, ivd;
    logic [63:0] nv [64];
    logic [63:0] a, b, c, old0;
    string       rq;
    op  = ins[20:19];
    va  = int'(ins[18:16]);
    vb  = int'(ins[15:13]);
    vc  = int'(ins[12:10]);
    vd  = int'(ins[9:7]);
    n   = (int'(ins[6:0]) > 64) ? 64 : int'(ins[6:0]);
    lat = (op == 2'd0) ? 6 : (op == 2'd1) ? 7 : 13;
    rq  = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : "R4";
    ivd = int'(intr_ins[9:7]);
    for (int i = 0; i < 64; i++) begin
      nv[i] = mdl[vd][i];
      if (i < n) begin
        a = mdl[va][i]; b = mdl[vb][i]; c = mdl[vc][i];
        nv[i] = (op == 2'd0) ? a + b : (op == 2'd1) ? a * b : (a + b) * c;
      end
    end
    old0 = mdl[vd][0];

    @(negedge clk);
    drive_issue(ins);
    dbg_reg = 3'(vd);
    dbg_idx = 6'd0;
    @(posedge clk);             // accepting edge E
    #1 iss_valid = 1'b0;
    mfirst = -1;
    mdone  = -1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);           // after edge E+k
      if (k == 0) chk(busy == (n != 0), (n == 0) ? "R9" : "R6", "busy after accept", 64'(busy), 64'(n != 0));
      if (intr_at >= 0 && k == intr_at) drive_issue(intr_ins);
      if (intr_at >= 0 && k == intr_at + 2) iss_valid = 1'b0;
      if (mfirst < 0 && n > 0 && dbg_data == nv[0]) mfirst = k;
      if (done) begin
        mdone = k;
        break;
      end
    end
    iss_valid = 1'b0;
    if (n == 0) chk(mdone == 0, "R9", "empty done time", 64'(mdone), 64'd0);
    else chk(mdone == lat + n - 1, (int'(ins[6:0]) > 64) ? "R6 R10" : "R6",
             "done time", 64'(mdone), 64'(lat + n - 1));
    if (n > 0 && nv[0] != old0)
      chk(mfirst == lat, "R5", "first element write time", 64'(mfirst), 64'(lat));
    @(negedge clk);
    chk(!done, "R6", "done pulse width", 64'(done), 64'd0);

    if (intr_at >= 0) begin
      quiet_bad = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (busy || done) quiet_bad++;
      end
      chk(quiet_bad == 0, "R7", "no run after rejected issue", 64'(quiet_bad), 64'd0);
    end

    for (int i = 0; i < 64; i++) mdl[vd][i] = nv[i];
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      dbg_reg = 3'(vd);
      dbg_idx = 6'(i);
      #1;
      chk(dbg_data == mdl[vd][i], (i < n) ? rq : ((n == 0) ? "R9" : "R8"),
          $sformatf("v%0d[%0d]", vd, i), dbg_data, mdl[vd][i]);
    end
    if (intr_at >= 0) begin
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        dbg_reg = 3'(ivd);
        dbg_idx = 6'(i);
        #1;
        chk(dbg_data == mdl[ivd][i], "R7", $sformatf("rejected target v%0d[%0d]", ivd, i),
            dbg_data, mdl[ivd][i]);
      end
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iss_valid = 1'b0; iss_op = '0; iss_va = '0; iss_vb = '0; iss_vc = '0; iss_vd = '0; iss_len = '0;
    ld_we = 1'b0; ld_reg = '0; ld_idx = '0; ld_data = '0;
    dbg_reg = '0; dbg_idx = '0;
    repeat (3) @(negedge clk);
    chk(!busy, "R11", "busy in reset", 64'(busy), 64'd0);
    chk(!done, "R11", "done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R11", "idle after reset", 64'({busy, done}), 64'd0);

    // fill every register through the load port
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        ld_we = 1'b1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = pat(r, i);
        mdl[r][i] = pat(r, i);
      end
    end
    @(negedge clk);
    ld_we = 1'b0;
    for (int r = 0; r < 8; r++) begin
      for (int s = 0; s < 3; s++) begin
        int i;
        i = (s == 0) ? 0 : (s == 1) ? 63 : r * 7;
        dbg_reg = 3'(r); dbg_idx = 6'(i);
        #1;
        chk(dbg_data == mdl[r][i], "R1", $sformatf("load v%0d[%0d]", r, i), dbg_data, mdl[r][i]);
      end
    end

    // table walk
    for (int t = 0; t < 8; t++) run_instr(TBL[t], -1, '0);

    // R7: issue attempted while a chained run is in flight
    run_instr({2'd2, 3'd3, 3'd4, 3'd5, 3'd0, 7'd64}, 3, {2'd0, 3'd6, 3'd6, 3'd0, 3'd7, 7'd64});

    // R9: empty instruction
    run_instr({2'd0, 3'd1, 3'd2, 3'd0, 3'd3, 7'd0}, -1, '0);

    // R11: reset arriving in the middle of a run
    @(negedge clk);
    drive_issue({2'd2, 3'd0, 3'd1, 3'd2, 3'd7, 7'd64});
    @(posedge clk);
    #1 iss_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy, "R11", "busy before mid-run reset", 64'(busy), 64'd1);
    rst_n = 1'b0;
    #1;
    chk(!busy && !done, "R11", "mid-run reset clears", 64'({busy, done}), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(!busy && !done, "R11", "quiet after mid-run reset", 64'({busy, done}), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule